// File: doc/BRIEF.md
# Multicore Boot Release Spin Table

This block is a memory-mapped table that holds one boot-release record for each secondary processor core in a multicore cluster. Boot software writes a start address and an argument into a core's record over a simple valid/ready register port. It may also read any record back. Every record is 32 bytes long and is stored most-significant byte first. The port accepts byte, halfword and word accesses at any offset inside a record.

A core is held while bit 0 of its 64-bit start address is 1. When an accepted write leaves that bit at 0, the block emits a single-cycle release pulse on the core's bit of a release vector. The pulse comes with the launch parameters for that core: the entry offset inside a 64 MB mapping window, the base of that window, the argument value, the window size and the log4 page-size code of the window. The record's processor-ID word is restored to the core's index on release. A present-core mask tells the block which records belong to real cores. Writes to absent cores and to the primary core (record 0) are dropped.

Top module: `boot_release_table`

## Requirements
- R1: After reset, record i reads back start address 1, argument i and processor ID i. Both reserved fields read 0.
- R2: Record layout in byte offsets: start address at bytes 0..7, argument at 8..15, a reserved word at 16..19, processor ID at 20..23 and a reserved doubleword at 24..31. Multi-byte fields are big-endian. A read of size code 0, 1 or 2 (1, 2 or 4 bytes) returns the bytes starting at the addressed byte, right-aligned in rsp_rdata, with the lowest address in the most significant returned byte.
- R3: A write of size code 0, 1 or 2 changes only the addressed bytes. The least significant byte of req_wdata lands at the highest addressed byte.
- R4: Writes to record 0 and to any record whose core_present bit is 0 are acknowledged without error and change nothing. Such writes never cause a release.
- R5: After an accepted write that leaves bit 0 of the record's start address at 0, rel_pulse has exactly that record's bit set for one cycle. The pulse appears in the same cycle as the write's response.
- R6: Once a core is released, it is not released again until an accepted write has made its start address odd and a later one has made it even again. A core is armed after reset.
- R7: With a pulse, rel_start_off is the start address modulo 2^26 and rel_map_base is the start address with its low 26 bits cleared. rel_arg is the record's argument and rel_win_size is 2^26.
- R8: rel_page_code is 8, which is trailing-zeros(window size / 1024) / 2.
- R9: On release, the record's processor-ID word is rewritten with the record index.
- R10: Size code 3 (8 bytes), and any access that would run past the end of its record, gets rsp_err set and has no effect.
- R11: req_ready is always 1. Every request gets exactly one response, with rsp_valid set in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_present | input | 32 | One bit per record; set when that core exists |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address; bits 9:5 select the record, bits 4:0 the byte |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes (rejected) |
| req_wdata | input | 32 | Write value, right-aligned |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read value, right-aligned; 0 for writes and errors |
| rsp_err | output | 1 | Rejected access |
| rel_pulse | output | 32 | One-cycle release, one bit per core |
| rel_start_off | output | 64 | Start offset inside the mapping window |
| rel_arg | output | 64 | Argument for the released core |
| rel_map_base | output | 64 | Window-aligned mapping base |
| rel_win_size | output | 64 | Mapping window size in bytes |
| rel_page_code | output | 5 | Log4-encoded page-size code of the window |

## Verification
The assertions assume that core_present is steady for the cycle of a request, and that a request is never held across a reset. The bench keeps the mask fixed for the whole run and drives one request per two cycles, so each release pulse can be matched to a single write. The mask leaves the primary core marked present and a few secondary cores absent, so the drop rules are exercised separately. The random writes are biased towards the low start-address word with a random bit 0, which walks the cores through many odd-to-even transitions.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam int REC_BYTES = 32;
    localparam int REC_BITS  = REC_BYTES * 8;

    typedef logic [REC_BITS-1:0] rec_t;

    // field bit positions within a record (byte 0 is the top byte)
    localparam int START_HI = REC_BITS - 1;
    localparam int START_LO = REC_BITS - 64;
    localparam int ARG_HI   = START_LO - 1;
    localparam int ARG_LO   = START_LO - 64;
    localparam int PID_HI   = 95;
    localparam int PID_LO   = 64;

    function automatic rec_t reset_rec(input int idx);
        rec_t r;
        r = '0;
        r[START_HI:START_LO] = 64'd1;
        r[ARG_HI:ARG_LO]     = 64'(idx);
        r[PID_HI:PID_LO]     = 32'(idx);
        return r;
    endfunction

    function automatic int unsigned trailing_zeros(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) n = 32'(i);
        end
        if (v == '0) n = 64;
        return n;
    endfunction

    function automatic int unsigned page_code_of(input int win_log2);
        logic [63:0] sz;
        sz = 64'd1 << win_log2;
        return trailing_zeros(sz >> 10) / 2;
    endfunction

    function automatic int size_bytes(input logic [1:0] sz);
        return (sz == 2'd3) ? 0 : (1 << sz);
    endfunction

endpackage

// File: rtl/br_write_merge.sv
module br_write_merge
    import br_pkg::*;
(
    input  rec_t        cur_i,
    input  logic [4:0]  off_i,
    input  logic [1:0]  size_i,
    input  logic [31:0] wdata_i,
    output rec_t        merged_o
);
    int nb;
    int o;

    always_comb begin
        merged_o = cur_i;
        nb = size_bytes(size_i);
        o  = int'(off_i);
        for (int k = 0; k < 4; k++) begin
            if (k < nb && (o + k) < REC_BYTES) begin
                merged_o[(REC_BYTES - 1 - (o + k)) * 8 +: 8] = wdata_i[(nb - 1 - k) * 8 +: 8];
            end
        end
    end
endmodule

// File: rtl/br_read_extract.sv
module br_read_extract
    import br_pkg::*;
(
    input  rec_t        rec_i,
    input  logic [4:0]  off_i,
    input  logic [1:0]  size_i,
    output logic [31:0] rdata_o
);
    int nb;
    int o;

    always_comb begin
        rdata_o = '0;
        nb = size_bytes(size_i);
        o  = int'(off_i);
        for (int k = 0; k < 4; k++) begin
            if (k < nb && (o + k) < REC_BYTES) begin
                rdata_o[(nb - 1 - k) * 8 +: 8] = rec_i[(REC_BYTES - 1 - (o + k)) * 8 +: 8];
            end
        end
    end
endmodule

// File: rtl/br_release_params.sv
module br_release_params #(
    parameter int WIN_LOG2 = 26
) (
    input  logic [63:0] start_i,
    output logic [63:0] off_o,
    output logic [63:0] base_o
);
    localparam logic [63:0] WIN_MASK = (64'd1 << WIN_LOG2) - 64'd1;

    always_comb begin
        off_o  = start_i & WIN_MASK;
        base_o = start_i & ~WIN_MASK;
    end
endmodule

// File: rtl/boot_release_table.sv
module boot_release_table
    import br_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int WIN_LOG2    = 26
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_ENTRIES-1:0]             core_present,
    input  logic                               req_valid,
    output logic                               req_ready,
    input  logic                               req_write,
    input  logic [$clog2(NUM_ENTRIES)+4:0]     req_addr,
    input  logic [1:0]                         req_size,
    input  logic [31:0]                        req_wdata,
    output logic                               rsp_valid,
    output logic [31:0]                        rsp_rdata,
    output logic                               rsp_err,
    output logic [NUM_ENTRIES-1:0]             rel_pulse,
    output logic [63:0]                        rel_start_off,
    output logic [63:0]                        rel_arg,
    output logic [63:0]                        rel_map_base,
    output logic [63:0]                        rel_win_size,
    output logic [4:0]                         rel_page_code
);
    localparam int IDX_W  = $clog2(NUM_ENTRIES);
    localparam int ADDR_W = IDX_W + 5;
    localparam logic [63:0] WIN_SIZE  = 64'd1 << WIN_LOG2;
    localparam logic [4:0]  PAGE_CODE = 5'(page_code_of(WIN_LOG2));

    typedef struct packed {
        logic [NUM_ENTRIES-1:0][REC_BITS-1:0] rec;
        logic [NUM_ENTRIES-1:0]               armed;
        logic                                 rsp_valid;
        logic                                 rsp_err;
        logic [31:0]                          rsp_rdata;
        logic [NUM_ENTRIES-1:0]               rel_pulse;
        logic [63:0]                          rel_off;
        logic [63:0]                          rel_arg;
        logic [63:0]                          rel_base;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] idx;
    logic [4:0]       off;
    logic             bad;
    logic             take;
    rec_t             cur, merged, nxt;
    logic [31:0]      rd_data;
    logic [63:0]      new_start, par_off, par_base;

    assign idx = req_addr[ADDR_W-1:5];
    assign off = req_addr[4:0];
    assign cur = st_q.rec[idx];

    br_write_merge u_merge (
        .cur_i    (cur),
        .off_i    (off),
        .size_i   (req_size),
        .wdata_i  (req_wdata),
        .merged_o (merged)
    );

    br_read_extract u_read (
        .rec_i   (cur),
        .off_i   (off),
        .size_i  (req_size),
        .rdata_o (rd_data)
    );

    assign new_start = merged[START_HI:START_LO];

    br_release_params #(.WIN_LOG2(WIN_LOG2)) u_params (
        .start_i (new_start),
        .off_o   (par_off),
        .base_o  (par_base)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_rdata = '0;
        st_d.rel_pulse = '0;
        nxt            = merged;

        bad  = (req_size == 2'd3) || ((6'(off) + 6'(size_bytes(req_size))) > 6'(REC_BYTES));
        take = req_valid && req_write && !bad && (idx != '0) && core_present[idx];

        if (req_valid) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_err   = bad;
            if (!req_write && !bad) st_d.rsp_rdata = rd_data;
        end

        if (take) begin
            if (!new_start[0]) begin
                if (st_q.armed[idx]) begin
                    st_d.rel_pulse[idx] = 1'b1;
                    st_d.armed[idx]     = 1'b0;
                    st_d.rel_off        = par_off;
                    st_d.rel_base       = par_base;
                    st_d.rel_arg        = merged[ARG_HI:ARG_LO];
                    nxt[PID_HI:PID_LO]  = 32'(idx);
                end
            end else begin
                st_d.armed[idx] = 1'b1;
            end
            st_d.rec[idx] = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                st_q.rec[i] <= reset_rec(i);
            end
            st_q.armed     <= '1;
            st_q.rsp_valid <= 1'b0;
            st_q.rsp_err   <= 1'b0;
            st_q.rsp_rdata <= '0;
            st_q.rel_pulse <= '0;
            st_q.rel_off   <= '0;
            st_q.rel_arg   <= '0;
            st_q.rel_base  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready     = 1'b1;
    assign rsp_valid     = st_q.rsp_valid;
    assign rsp_err       = st_q.rsp_err;
    assign rsp_rdata     = st_q.rsp_rdata;
    assign rel_pulse     = st_q.rel_pulse;
    assign rel_start_off = st_q.rel_off;
    assign rel_arg       = st_q.rel_arg;
    assign rel_map_base  = st_q.rel_base;
    assign rel_win_size  = WIN_SIZE;
    assign rel_page_code = PAGE_CODE;

    // R5
    no_multi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_pulse));

    // R5
    no_unprompted_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_pulse) |-> $past(req_valid && req_write));

    // R4
    no_primary_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_pulse[0]);

    // R4
    no_absent_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_pulse) |-> ((rel_pulse & ~$past(core_present)) == '0));

    // R11
    no_orphan_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R11
    no_lost_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    no_wide_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd3) |=> (rsp_err && rsp_rdata == '0));

endmodule

// File: tb/test_boot_release_table.sv
module test_boot_release_table;
    localparam int NE = 32;
    localparam logic [31:0] PRESENT = 32'hDF7F_FFEF;
    localparam logic [63:0] WMASK = (64'd1 << 26) - 64'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] core_present = PRESENT;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [31:0] rel_pulse;
    logic [63:0] rel_start_off, rel_arg, rel_map_base, rel_win_size;
    logic [4:0]  rel_page_code;

    always #5 clk = ~clk;

    boot_release_table i_boot_release_table (
        .clk(clk), .rst_n(rst_n), .core_present(core_present),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .rel_pulse(rel_pulse), .rel_start_off(rel_start_off), .rel_arg(rel_arg),
        .rel_map_base(rel_map_base), .rel_win_size(rel_win_size),
        .rel_page_code(rel_page_code)
    );

    logic [7:0] mem [NE][32];
    bit         armed [NE];
    int         n_chk = 0;
    int         n_bad = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] field64(input int e, input int base);
        logic [63:0] v = '0;
        for (int k = 0; k < 8; k++) v = (v << 8) | 64'(mem[e][base + k]);
        return v;
    endfunction

    task automatic model_reset();
        for (int e = 0; e < NE; e++) begin
            for (int b = 0; b < 32; b++) mem[e][b] = 8'h00;
            mem[e][7]  = 8'h01;
            mem[e][15] = 8'(e);
            mem[e][23] = 8'(e);
            armed[e]   = 1'b1;
        end
    endtask

    task automatic access(input bit wr, input int addr, input int sz,
                          input logic [31:0] wd, input string tag);
        int e, off, nb;
        bit bad;
        logic [31:0] er;
        logic [31:0] ep;
        logic [63:0] st, ar;
        e   = addr / 32;
        off = addr % 32;
        nb  = (sz == 3) ? 8 : (1 << sz);
        bad = (sz == 3) || (off + nb > 32);
        @(negedge clk);
        chk("R5", 64'(rel_pulse), 64'd0, "pulse not cleared after one cycle");
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 10'(addr);
        req_size  = 2'(sz);
        req_wdata = wd;
        er = '0;
        if (!wr && !bad) for (int k = 0; k < nb; k++) er = (er << 8) | 32'(mem[e][off + k]);
        ep = '0;
        st = '0;
        ar = '0;
        if (wr && !bad && e != 0 && PRESENT[e]) begin
            for (int k = 0; k < nb; k++) mem[e][off + k] = wd[(nb - 1 - k) * 8 +: 8];
            st = field64(e, 0);
            ar = field64(e, 8);
            if (!st[0]) begin
                if (armed[e]) begin
                    ep[e]    = 1'b1;
                    armed[e] = 1'b0;
                    for (int k = 0; k < 4; k++) mem[e][20 + k] = 8'(e >> (8 * (3 - k)));
                end
            end else begin
                armed[e] = 1'b1;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", 64'(rsp_valid), 64'd1, "response valid");
        chk("R11", 64'(req_ready), 64'd1, "ready");
        chk("R10", 64'(rsp_err), 64'(bad), "error flag");
        chk(tag, 64'(rsp_rdata), 64'(er), "read data");
        chk("R5 R6", 64'(rel_pulse), 64'(ep), "release vector");
        if (ep != 0) begin
            chk("R7", rel_start_off, st & WMASK, "start offset");
            chk("R7", rel_map_base, st & ~WMASK, "map base");
            chk("R7", rel_arg, ar, "argument");
            chk("R7", rel_win_size, 64'd1 << 26, "window size");
            chk("R8", 64'(rel_page_code), 64'd8, "page code");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int e, kind, off, sz;
        logic [31:0] v;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", 64'(rsp_valid), 64'd0, "idle after reset");

        // R1 reset contents
        access(0, 5 * 32 + 20, 2, 0, "R1");
        access(0, 5 * 32 + 12, 2, 0, "R1");
        access(0, 5 * 32 + 4, 2, 0, "R1");
        access(0, 5 * 32 + 0, 2, 0, "R1");
        access(0, 31 * 32 + 20, 2, 0, "R1");
        access(0, 31 * 32 + 28, 2, 0, "R1");
        // R2 narrow big-endian reads
        access(0, 7 * 32 + 23, 0, 0, "R2");
        access(0, 7 * 32 + 22, 1, 0, "R2");
        access(0, 7 * 32 + 6, 1, 0, "R2");
        // R3 partial writes
        access(1, 9 * 32 + 16, 0, 32'hAB, "R3");
        access(1, 9 * 32 + 18, 1, 32'h1234, "R3");
        access(0, 9 * 32 + 16, 2, 0, "R3");
        // R4 primary and absent cores
        access(1, 0 * 32 + 4, 2, 32'h0000_1000, "R4");
        access(0, 0 * 32 + 4, 2, 0, "R4");
        access(1, 4 * 32 + 4, 2, 32'h0000_2000, "R4");
        access(0, 4 * 32 + 4, 2, 0, "R4");
        // R5 R7 release with high address bits
        access(1, 3 * 32 + 0, 2, 32'h0000_0012, "R5");
        access(1, 3 * 32 + 8, 2, 32'hCAFE_0001, "R7");
        access(1, 3 * 32 + 4, 2, 32'h0567_89A0, "R5");
        // R6 no re-release until odd then even
        access(1, 3 * 32 + 4, 2, 32'h0000_4000, "R6");
        access(1, 3 * 32 + 7, 0, 32'h03, "R6");
        access(1, 3 * 32 + 7, 0, 32'h08, "R6");
        // R9 processor-ID restored on release
        access(1, 6 * 32 + 20, 2, 32'hDEAD_BEEF, "R9");
        access(0, 6 * 32 + 20, 2, 0, "R9");
        access(1, 6 * 32 + 4, 2, 32'h0010_0000, "R9");
        access(0, 6 * 32 + 20, 2, 0, "R9");
        // R10 wide and crossing accesses
        access(0, 8 * 32 + 0, 3, 0, "R10");
        access(1, 8 * 32 + 30, 2, 32'h0000_0000, "R10");
        access(1, 8 * 32 + 31, 1, 32'h0000_0000, "R10");
        access(0, 8 * 32 + 28, 2, 0, "R10");
        access(0, 8 * 32 + 4, 2, 0, "R10");

        // random mix
        for (int n = 0; n < 1500; n++) begin
            e    = $urandom_range(0, NE - 1);
            kind = $urandom_range(0, 9);
            v    = $urandom;
            if (kind <= 3) begin
                access(1, e * 32 + 4, 2, v, "R5");
            end else if (kind == 4) begin
                access(1, e * 32 + 0, 2, v, "R3");
            end else if (kind <= 7) begin
                off = $urandom_range(0, 31);
                sz  = $urandom_range(0, 2);
                access(0, e * 32 + off, sz, 0, "R2");
            end else if (kind == 8) begin
                off = $urandom_range(0, 31);
                sz  = $urandom_range(0, 2);
                access(1, e * 32 + off, sz, v, "R3");
            end else begin
                access($urandom_range(0, 1) == 1, e * 32 + $urandom_range(0, 31), 3, v, "R10");
            end
        end

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule